// File: doc/BRIEF.md
# Per-Core Interrupt Enable and Summary Fan-Out

This unit gathers interrupt sources into two summary words, group 0 and group 1, each `SRC_W` bits wide with one bit per source. Every core owns two enable banks: one masks group 0 and one masks group 1. Each core receives one interrupt line per group. A line is high whenever the group's summary, masked by that core's bank for the group, has any bit set. Software reaches the enable banks through a simple register port. Each bank has three views. The plain view can be read and fully rewritten. The set view ORs a written mask into the bank. The clear view removes a written mask from the bank. With the set and clear views, one bit can change without a read-modify-write.

In group 0, a parameter mask selects which bits are latched. A latched bit sets on a rising edge of its source. It stays set until software writes a 1 to that bit through the summary view. All other summary bits are level bits: they follow their source inputs and ignore writes. Group 1 has its own latch mask, which by default makes every group 1 bit a level bit.

Top module: `irq_fanout_unit`

## Requirements
- R1: After reset, every enable bank reads zero and every interrupt line is low.
- R2: The address is formed as {view[1:0], bank[2:0]}, with bank = 2*core + group. View 0 is the plain view: a write replaces the whole bank, and a read of views 0, 1 or 2 returns the bank's current value.
- R3: A write to view 1 (set) ORs the data into the bank. Bits written as 0 leave the bank unchanged.
- R4: A write to view 2 (clear) clears the bank bits that are written as 1. Bits written as 0 leave the bank unchanged.
- R5: Bank 2*c masks group 0 and drives only `irq_grp0[c]`. Bank 2*c+1 masks group 1 and drives only `irq_grp1[c]`.
- R6: A line is high exactly when (summary AND enable bank) is nonzero. An enabled bit whose source is idle does not raise the line.
- R7: Level summary bits equal their source inputs. A write to view 3 (summary) leaves them unchanged.
- R8: A latched bit sets on a rising source edge and stays set after the source drops. A view 3 write clears it only where the data bit is 1. Bank bit 0 of a view 3 address selects the group. The default latch mask for group 0 is bits 63..56.
- R9: If a rising edge and a clearing write hit the same latched bit in the same cycle, the bit ends up set.
- R10: A read of view 3 returns the summary word of the group selected by bank bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | {view, bank index} |
| reg_wdata | input | SRC_W | Write data or mask |
| reg_rdata | output | SRC_W | Read data for reg_addr (combinational) |
| src_grp0 | input | SRC_W | Group 0 source inputs |
| src_grp1 | input | SRC_W | Group 1 source inputs |
| irq_grp0 | output | NUM_CORES | Group 0 line for each core |
| irq_grp1 | output | NUM_CORES | Group 1 line for each core |

## Verification
A latched bit can see a rising source edge and a clearing summary write in the same clock cycle. The bench provokes this by raising the source of bit 61 on the same edge that carries a write of 1 to bit 61 through the summary view. It then reads the summary back and expects the bit to still be set. Next, it clears the bit with a write alone and expects it to read zero. This shows that the earlier result came from set priority and not from a clear that failed.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic [1:0] {
        VIEW_PLAIN = 2'd0,
        VIEW_SET   = 2'd1,
        VIEW_CLR   = 2'd2,
        VIEW_SUM   = 2'd3
    } reg_view_e;
endpackage

// File: rtl/irqf_en_bank.sv
module irqf_en_bank #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_plain,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    logic [W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= '0;
        else if (wr_plain) en_q <= wdata;
        else if (wr_set)   en_q <= en_q | wdata;
        else if (wr_clr)   en_q <= en_q & ~wdata;
    end

    assign en = en_q;

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set && !wr_plain |=> ((en & $past(wdata)) == $past(wdata)));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr && !wr_plain && !wr_set |=> ((en & $past(wdata)) == '0));

    // R3 R4
    zero_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) && !wr_plain |=>
            ((en & ~$past(wdata)) == ($past(en) & ~$past(wdata))));
endmodule

// File: rtl/irqf_summary.sv
module irqf_summary #(
    parameter int           W          = 64,
    parameter logic [W-1:0] LATCH_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] sum
);
    logic [W-1:0] src_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_v;

    assign rise  = src & ~src_q & LATCH_MASK;
    assign clr_v = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            lat_q <= '0;
        end else begin
            src_q <= src;
            // an edge this cycle outranks a clear this cycle
            lat_q <= (rise | (lat_q & ~clr_v)) & LATCH_MASK;
        end
    end

    assign sum = lat_q | (src & ~LATCH_MASK);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((sum & $past(sum) & LATCH_MASK) == ($past(sum) & LATCH_MASK)));

    // R8
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && (rise == '0) |=> ((sum & $past(clr_mask) & LATCH_MASK) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((sum & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_fanout_unit.sv
module irq_fanout_unit
    import irqf_pkg::*;
#(
    parameter int               NUM_CORES = 4,
    parameter int               SRC_W     = 64,
    parameter logic [SRC_W-1:0] LATCH0    = 64'hFF00_0000_0000_0000,
    parameter logic [SRC_W-1:0] LATCH1    = '0,
    localparam int              NBANK     = 2 * NUM_CORES,
    localparam int              BANK_W    = $clog2(NBANK),
    localparam int              ADDR_W    = BANK_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [SRC_W-1:0]     reg_wdata,
    output logic [SRC_W-1:0]     reg_rdata,
    input  logic [SRC_W-1:0]     src_grp0,
    input  logic [SRC_W-1:0]     src_grp1,
    output logic [NUM_CORES-1:0] irq_grp0,
    output logic [NUM_CORES-1:0] irq_grp1
);
    reg_view_e         view;
    logic [BANK_W-1:0] bank;
    logic [SRC_W-1:0]  en_v [NBANK];
    logic [SRC_W-1:0]  sum0;
    logic [SRC_W-1:0]  sum1;

    assign view = reg_view_e'(reg_addr[ADDR_W-1 -: 2]);
    assign bank = reg_addr[BANK_W-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = reg_we && (bank == BANK_W'(b));
        irqf_en_bank #(.W(SRC_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_plain (hit && view == VIEW_PLAIN),
            .wr_set   (hit && view == VIEW_SET),
            .wr_clr   (hit && view == VIEW_CLR),
            .wdata    (reg_wdata),
            .en       (en_v[b])
        );
    end

    irqf_summary #(.W(SRC_W), .LATCH_MASK(LATCH0)) u_sum0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_grp0),
        .clr_we   (reg_we && view == VIEW_SUM && !bank[0]),
        .clr_mask (reg_wdata),
        .sum      (sum0)
    );

    irqf_summary #(.W(SRC_W), .LATCH_MASK(LATCH1)) u_sum1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_grp1),
        .clr_we   (reg_we && view == VIEW_SUM && bank[0]),
        .clr_mask (reg_wdata),
        .sum      (sum1)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign irq_grp0[c] = |(sum0 & en_v[2*c]);
        assign irq_grp1[c] = |(sum1 & en_v[2*c+1]);
    end

    always_comb begin
        unique case (view)
            VIEW_SUM: reg_rdata = bank[0] ? sum1 : sum0;
            default:  reg_rdata = en_v[bank];
        endcase
    end
endmodule

// File: tb/irq_fanout_unit_bench.sv
`timescale 1ns/1ps
module irq_fanout_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [63:0] src_grp0 = '0;
    logic [63:0] src_grp1 = '0;
    logic [3:0]  irq_grp0;
    logic [3:0]  irq_grp1;
    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] d;

    always #10 clk = ~clk;

    irq_fanout_unit u_irq_fanout_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_grp0(src_grp0), .src_grp1(src_grp1),
        .irq_grp0(irq_grp0), .irq_grp1(irq_grp1)
    );

    // {view[1:0], bank[2:0], wdata, expected read of same address}
    localparam logic [132:0] VEC [8] = '{
        {2'd0, 3'd0, 64'h00FF_0000_1234_5678, 64'h00FF_0000_1234_5678},
        {2'd1, 3'd0, 64'hF000_0000_0000_0001, 64'hF0FF_0000_1234_5679},
        {2'd2, 3'd0, 64'h00F0_0000_0000_0078, 64'hF00F_0000_1234_5601},
        {2'd2, 3'd0, 64'h0,                   64'hF00F_0000_1234_5601},
        {2'd1, 3'd5, 64'h0,                   64'h0},
        {2'd0, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {2'd2, 3'd7, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
        {2'd0, 3'd0, 64'h0,                   64'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_we = 0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int b = 0; b < 8; b++) begin
            rd({2'd0, 3'(b)}, d);
            chk("R1", d, 64'h0);
        end
        chk("R1", {56'h0, irq_grp1, irq_grp0}, 64'h0);

        // R2 R3 R4: vector table
        for (int i = 0; i < 8; i++) begin
            logic [4:0] a;
            string tag;
            a = VEC[i][132:128];
            tag = (a[4:3] == 2'd0) ? "R2" : (a[4:3] == 2'd1) ? "R3" : "R4";
            wr(a, VEC[i][127:64]);
            rd(a, d);
            chk(tag, d, VEC[i][63:0]);
        end

        // R5 R6: bank-to-line mapping
        wr({2'd0, 3'd7}, 64'h0);
        @(negedge clk); src_grp0 = 64'h20;
        wr({2'd1, 3'd2}, 64'h20);
        #1 chk("R5", {60'h0, irq_grp0}, 64'h2);
        chk("R5", {60'h0, irq_grp1}, 64'h0);
        @(negedge clk); src_grp1 = 64'h200;
        wr({2'd1, 3'd7}, 64'h200);
        #1 chk("R5", {60'h0, irq_grp1}, 64'h8);
        wr({2'd0, 3'd2}, 64'h40);
        #1 chk("R6", {60'h0, irq_grp0}, 64'h0);
        @(negedge clk); src_grp0 = 64'h60;
        #1 chk("R6", {60'h0, irq_grp0}, 64'h2);

        // R7: level bits ignore summary writes
        wr({2'd3, 3'd0}, 64'h60);
        rd({2'd3, 3'd0}, d);
        chk("R7", d, 64'h60);
        @(negedge clk); src_grp0 = 64'h0;
        rd({2'd3, 3'd0}, d);
        chk("R7", d, 64'h0);
        // R10: group 1 summary
        rd({2'd3, 3'd1}, d);
        chk("R10", d, 64'h200);
        @(negedge clk); src_grp1 = 64'h0;

        // R8: latched bit 60
        @(negedge clk); src_grp0 = 64'h1000_0000_0000_0000;
        rd({2'd3, 3'd0}, d);
        chk("R8", d, 64'h1000_0000_0000_0000);
        @(negedge clk); src_grp0 = 64'h0;
        rd({2'd3, 3'd0}, d);
        chk("R8", d, 64'h1000_0000_0000_0000);
        wr({2'd3, 3'd0}, 64'h0);
        rd({2'd3, 3'd0}, d);
        chk("R8", d, 64'h1000_0000_0000_0000);
        wr({2'd3, 3'd0}, 64'h1000_0000_0000_0000);
        rd({2'd3, 3'd0}, d);
        chk("R8", d, 64'h0);

        // R9: edge and clear in the same cycle on bit 61
        @(negedge clk);
        src_grp0 = 64'h2000_0000_0000_0000;
        reg_we = 1; reg_addr = {2'd3, 3'd0}; reg_wdata = 64'h2000_0000_0000_0000;
        @(negedge clk); reg_we = 0;
        rd({2'd3, 3'd0}, d);
        chk("R9", d, 64'h2000_0000_0000_0000);
        wr({2'd3, 3'd0}, 64'h2000_0000_0000_0000);
        rd({2'd3, 3'd0}, d);
        chk("R9", d, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule